// File: doc/BRIEF.md
# SHA-512 Schedule Partial Sigma Unit

This block performs the first half of a SHA-512 message-schedule expansion step on four consecutive 64-bit message words at once. A wide operand carries four words in its lanes. A half-width operand carries one more word in its low lane. Each output lane receives its own word plus the small sigma-0 of the word in the slot above it. For the top lane, the slot above is the low lane of the half-width operand.

The result is registered once. A valid strobe travels alongside the data, so a datapath can issue one operation per clock and collect the four partial sums one cycle later. The sigma-1 terms, round constants, padding and compression rounds are outside this block.

Top module: `sha512_psig`

## Requirements
- R1: Small sigma-0 of a word x is rotr(x, ROT_LO) XOR rotr(x, ROT_HI) XOR (x >> SHR_N). The defaults are 1, 8 and 7, which give the SHA-512 function.
- R2: Word slot i (0 to LANES-1) is bits [i*W +: W] of `words_i`, and slot LANES is bits [W-1:0] of `next_i`. Output lane i, at bits [i*W +: W] of `sums_o`, equals slot i plus sigma-0 of slot i+1.
- R3: Each lane sum wraps modulo 2^W, and no carry crosses from one lane into the next.
- R4: Bits [2W-1:W] of `next_i` have no effect on `sums_o`.
- R5: Rotation counts are reduced modulo W, so a count of W rotates by zero. A shift count of W or more gives zero.
- R6: `out_valid_o` is high in the cycle after `in_valid_i` is sampled high, and low in the cycle after `in_valid_i` is sampled low.
- R7: `sums_o` loads only on a clock edge where `in_valid_i` is high, and otherwise holds its value.
- R8: When `rst_ni` is low, `out_valid_o` and `sums_o` are cleared at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands valid this cycle |
| words_i | input | W*LANES | Word slots 0 to LANES-1 |
| next_i | input | 2*W | Low lane is word slot LANES; high lane ignored |
| out_valid_o | output | 1 | Registered result valid |
| sums_o | output | W*LANES | Registered partial sums, one per lane |

## Verification
The bench builds two instances.

The first uses the default configuration: W=64, four lanes, counts 1/8/7. It is checked against a SHA-512 schedule model using all-zero, all-ones, single-bit and random words. The same instance is used for the ignored upper lane, hold, valid timing and mid-run reset checks.

The second uses W=4 with two lanes. At that width the count of 8 wraps to a zero rotation and the shift of 7 clears the word. This brings R5 within reach. It also makes an exhaustive sweep of all 4096 combinations of the three relevant 4-bit words practical.

// File: rtl/sha512_psig_pkg.sv
package sha512_psig_pkg;
  localparam int unsigned DEF_W      = 64;
  localparam int unsigned DEF_LANES  = 4;
  localparam int unsigned DEF_ROT_LO = 1;
  localparam int unsigned DEF_ROT_HI = 8;
  localparam int unsigned DEF_SHR_N  = 7;
endpackage

// File: rtl/ssp_sigma0.sv
module ssp_sigma0 #(
  parameter int unsigned W      = 64,
  parameter int unsigned ROT_LO = 1,
  parameter int unsigned ROT_HI = 8,
  parameter int unsigned SHR_N  = 7
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] s_o
);
  localparam int unsigned RL = ROT_LO % W;
  localparam int unsigned RH = ROT_HI % W;

  logic [W-1:0] rot_lo, rot_hi, shr;

  if (RL == 0) begin : g_rl0
    assign rot_lo = x_i;
  end else begin : g_rl
    assign rot_lo = {x_i[RL-1:0], x_i[W-1:RL]};
  end

  if (RH == 0) begin : g_rh0
    assign rot_hi = x_i;
  end else begin : g_rh
    assign rot_hi = {x_i[RH-1:0], x_i[W-1:RH]};
  end

  // shift count of W or more clears the word
  if (SHR_N >= W) begin : g_shz
    assign shr = '0;
  end else begin : g_sh
    assign shr = x_i >> SHR_N;
  end

  assign s_o = rot_lo ^ rot_hi ^ shr;
endmodule

// File: rtl/ssp_lane.sv
module ssp_lane #(
  parameter int unsigned W      = 64,
  parameter int unsigned ROT_LO = 1,
  parameter int unsigned ROT_HI = 8,
  parameter int unsigned SHR_N  = 7
) (
  input  logic [W-1:0] word_i,
  input  logic [W-1:0] upper_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] sig;

  ssp_sigma0 #(.W(W), .ROT_LO(ROT_LO), .ROT_HI(ROT_HI), .SHR_N(SHR_N)) sig_i (
    .x_i (upper_i),
    .s_o (sig)
  );

  assign sum_o = word_i + sig;  // wraps mod 2^W
endmodule

// File: rtl/ssp_out_reg.sv
module ssp_out_reg #(
  parameter int unsigned DW = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= data_i;
    end
  end

  p_valid_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
endmodule

// File: rtl/sha512_psig.sv
module sha512_psig
  import sha512_psig_pkg::*;
#(
  parameter int unsigned W      = DEF_W,
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned ROT_LO = DEF_ROT_LO,
  parameter int unsigned ROT_HI = DEF_ROT_HI,
  parameter int unsigned SHR_N  = DEF_SHR_N
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic [W*LANES-1:0] words_i,
  input  logic [2*W-1:0]     next_i,
  output logic               out_valid_o,
  output logic [W*LANES-1:0] sums_o
);
  localparam int unsigned VEC_W = W * LANES;

  logic [LANES:0][W-1:0] slot;
  logic [VEC_W-1:0]      sum_d;
  logic                  unused_next_hi;

  assign unused_next_hi = ^next_i[2*W-1:W];
  assign slot[LANES]    = next_i[W-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign slot[g] = words_i[g*W +: W];
    ssp_lane #(.W(W), .ROT_LO(ROT_LO), .ROT_HI(ROT_HI), .SHR_N(SHR_N)) lane_i (
      .word_i  (slot[g]),
      .upper_i (slot[g+1]),
      .sum_o   (sum_d[g*W +: W])
    );
  end

  ssp_out_reg #(.DW(VEC_W)) oreg_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .data_i  (sum_d),
    .valid_o (out_valid_o),
    .data_o  (sums_o)
  );

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> sums_o == $past(sum_d));
endmodule

// File: tb/sha512_psig_tb_top.sv
`timescale 1ns/1ps
module sha512_psig_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  // default instance
  logic         v_in = 1'b0;
  logic [255:0] words = '0;
  logic [127:0] nxt = '0;
  logic         v_out;
  logic [255:0] sums;

  sha512_psig dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(v_in), .words_i(words),
    .next_i(nxt), .out_valid_o(v_out), .sums_o(sums)
  );

  // small instance: W=4, 2 lanes
  logic       sv_in = 1'b0;
  logic [7:0] swords = '0;
  logic [7:0] snxt = '0;
  logic       sv_out;
  logic [7:0] ssums;

  sha512_psig #(.W(4), .LANES(2), .ROT_LO(1), .ROT_HI(8), .SHR_N(7)) dut_s_i (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(sv_in), .words_i(swords),
    .next_i(snxt), .out_valid_o(sv_out), .sums_o(ssums)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  function automatic logic [63:0] sig0(input logic [63:0] x);
    return {x[0], x[63:1]} ^ {x[7:0], x[63:8]} ^ (x >> 7);
  endfunction

  function automatic logic [255:0] model(input logic [255:0] w, input logic [63:0] n);
    logic [63:0] s [5];
    logic [255:0] r;
    for (int i = 0; i < 4; i++) s[i] = w[i*64 +: 64];
    s[4] = n;
    for (int i = 0; i < 4; i++) r[i*64 +: 64] = s[i] + sig0(s[i+1]);
    return r;
  endfunction

  // W=4: rot 1, rot 8 mod 4 = 0, shift 7 clears
  function automatic logic [3:0] ssig(input logic [3:0] x);
    return {x[0], x[3:1]} ^ x;
  endfunction

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run64(input string tag, input logic [255:0] w, input logic [127:0] n);
    @(negedge clk);
    words = w; nxt = n; v_in = 1'b1;
    @(negedge clk);
    v_in = 1'b0;
    chk({tag, " valid"}, {255'd0, v_out}, 256'd1);
    chk(tag, sums, model(w, n[63:0]));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [255:0] w, held;
    logic [127:0] n;
    logic [7:0] exp_s;
    repeat (3) @(negedge clk);
    chk("R8 reset valid", {255'd0, v_out}, '0);
    chk("R8 reset sums", sums, '0);
    rst_ni = 1'b1;

    run64("R2 zeros", '0, '0);
    run64("R3 all-ones", '1, {64'd0, {64{1'b1}}});
    for (int b = 0; b < 64; b++) begin
      w = '0;
      for (int l = 0; l < 4; l++) w[l*64 + ((b + l) % 64)] = 1'b1;
      n = '0; n[(b + 4) % 64] = 1'b1;
      run64("R1 single-bit", w, n);
    end
    for (int k = 0; k < 200; k++) begin
      for (int j = 0; j < 8; j++) w[j*32 +: 32] = $urandom;
      n = {$urandom, $urandom, $urandom, $urandom};
      run64("R2 random", w, n);
    end

    // R4: upper half of next_i has no effect
    for (int k = 0; k < 20; k++) begin
      for (int j = 0; j < 8; j++) w[j*32 +: 32] = $urandom;
      n = {64'd0, $urandom, $urandom};
      run64("R4 hi-zero", w, n);
      n[127:64] = {$urandom, $urandom} | 64'h1;
      run64("R4 hi-set", w, n);
    end

    // R6/R7: idle cycle drops valid, holds data
    held = sums;
    @(negedge clk);
    words = ~words; nxt = ~nxt;
    @(negedge clk);
    chk("R6 idle valid", {255'd0, v_out}, '0);
    chk("R7 hold", sums, held);

    // R8 asynchronous mid-run reset
    run64("R2 pre-reset", '1, '0);
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R8 async valid", {255'd0, v_out}, '0);
    chk("R8 async sums", sums, '0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R5 exhaustive on W=4 instance, back-to-back
    for (int i = 0; i < 4097; i++) begin
      @(negedge clk);
      if (i > 0) begin
        logic [3:0] w0, w1, n0;
        {n0, w1, w0} = 12'(i - 1);
        exp_s = {w1 + ssig(n0), w0 + ssig(w1)};
        chk("R5 small sweep", {248'd0, ssums}, {248'd0, exp_s});
        chk("R6 back-to-back valid", {255'd0, sv_out}, 256'd1);
      end
      if (i < 4096) begin
        swords = i[7:0];
        snxt = {4'(i * 7), i[11:8]};
        sv_in = 1'b1;
      end else sv_in = 1'b0;
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule